// File: doc/BRIEF.md
# Synchronizable PWM Time Base

This block is an up-counting PWM timer. Its counter runs from zero to a programmable period and wraps back to zero. A compare value sets the duty of one raw PWM output. A phase value can be forced into the counter by an external sync pulse. This lets several copies run in a chain with a fixed phase offset: one master pulses its sync output each time its counter passes zero, and every slave reloads its counter with its own phase value when that pulse arrives.

Period and compare writes land in shadow registers. They move into the active registers only in a cycle where the counter is zero, so a running period is never cut short or distorted. The phase value is written directly. A one-cycle interrupt pulse marks every counter-zero event, with no event prescaling.

Top module: `pwm_timebase`

## Requirements
- R1: With no phase load, the counter increments by one per clock while it is below the active period, and returns to 0 on the clock after it reaches or exceeds the active period.
- R2: A period write goes to a shadow register. The active period takes the shadow value at the end of a cycle in which the counter is 0. A write made in such a cycle is applied at the next zero cycle.
- R3: When phase_en is 1 and sync_in is 1 in a cycle, the counter holds the phase register value on the next clock. The phase register is written directly and has no shadow.
- R4: When phase_en is 0, sync_in has no effect on the counter.
- R5: The sync output is registered. When sync_sel is 0, sync_out is 1 in the cycle after each cycle with counter 0. When sync_sel is 1, sync_out repeats sync_in one cycle later.
- R6: A compare write goes to a shadow register and becomes active under the same zero-cycle rule as the period.
- R7: pwm_a is registered. It goes to 0 in the cycle after the counter equals the active compare value. Otherwise it goes to 1 in the cycle after the counter equals 0. If both events fall in the same cycle, the clear wins.
- R8: zero_irq is 1 exactly in the cycles that follow a cycle with counter 0. A phase load of a nonzero value never produces it.
- R9: While rst_n is low, the counter, pwm_a, zero_irq, sync_out and all period, compare and phase registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prd_wr | input | 1 | Period shadow write strobe |
| prd_wdata | input | CNT_W | Period write value |
| cmp_wr | input | 1 | Compare shadow write strobe |
| cmp_wdata | input | CNT_W | Compare write value |
| phs_wr | input | 1 | Phase register write strobe |
| phs_wdata | input | CNT_W | Phase write value |
| phase_en | input | 1 | 1: sync_in reloads the counter (slave); 0: sync_in ignored (master) |
| sync_sel | input | 1 | 0: sync_out on counter zero; 1: sync_out passes sync_in |
| sync_in | input | 1 | Sync pulse from upstream instance |
| cnt_o | output | CNT_W | Current counter value |
| pwm_a | output | 1 | Raw PWM output A |
| zero_irq | output | 1 | Counter-zero interrupt pulse |
| sync_out | output | 1 | Sync pulse to downstream instance |

## Verification
An active period or compare register that loads at the wrong time shows up within one period. In the period case the counter turns over at a value different from the one the shadow rules predict. In the compare case the falling edge of pwm_a moves. A wrong phase load or an ignored sync is visible at cnt_o on the very next clock. A stuck or misrouted zero event shows one cycle later on zero_irq, sync_out and the rising edge of pwm_a. The bench compares every output every cycle against a model built from these rules, so any such fault is reported in the cycle it first reaches a port.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;
   typedef enum logic {
      SYNC_SRC_ZERO = 1'b0,
      SYNC_SRC_PASS = 1'b1
   } sync_src_e;

   localparam int CNT_W_MIN = 2;
   localparam int CNT_W_MAX = 32;
endpackage

// File: rtl/pwmtb_shadow.sv
module pwmtb_shadow #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         load,
   output logic [W-1:0] active_q
);
   logic [W-1:0] shadow_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
         active_q <= '0;
      end else begin
         if (wr)
            shadow_q <= wdata;
         if (load)
            active_q <= shadow_q;
      end
   end
endmodule

// File: rtl/pwmtb_counter.sv
module pwmtb_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] period,
   input  logic [W-1:0] phase,
   input  logic         phase_take,
   output logic [W-1:0] cnt_q
);
   logic at_top;
   assign at_top = (cnt_q >= period);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (phase_take)
         cnt_q <= phase;
      else if (at_top)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/pwmtb_events.sv
module pwmtb_events #(
   parameter int W            = 16,
   parameter bit SYNC_OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] cmp,
   input  logic         sync_in,
   input  logic         sync_sel,
   output logic         pwm_a,
   output logic         zero_irq,
   output logic         sync_out
);
   import pwmtb_pkg::*;

   logic      ev_zero;
   logic      ev_cmp;
   logic      sync_next;
   sync_src_e src;

   assign ev_zero   = (cnt == '0);
   assign ev_cmp    = (cnt == cmp);
   assign src       = sync_src_e'(sync_sel);
   assign sync_next = (src == SYNC_SRC_PASS) ? sync_in : ev_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwm_a    <= 1'b0;
         zero_irq <= 1'b0;
      end else begin
         zero_irq <= ev_zero;
         if (ev_cmp)
            pwm_a <= 1'b0;
         else if (ev_zero)
            pwm_a <= 1'b1;
      end
   end

   generate
      if (SYNC_OUT_REG) begin : g_sync_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               sync_out <= 1'b0;
            else
               sync_out <= sync_next;
         end
      end else begin : g_sync_comb
         assign sync_out = rst_n & sync_next;
      end
   endgenerate
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int CNT_W        = 16,
   parameter bit SYNC_OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prd_wr,
   input  logic [CNT_W-1:0] prd_wdata,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic             phs_wr,
   input  logic [CNT_W-1:0] phs_wdata,
   input  logic             phase_en,
   input  logic             sync_sel,
   input  logic             sync_in,
   output logic [CNT_W-1:0] cnt_o,
   output logic             pwm_a,
   output logic             zero_irq,
   output logic             sync_out
);
   import pwmtb_pkg::*;

   generate
      if (CNT_W < CNT_W_MIN || CNT_W > CNT_W_MAX) begin : g_bad_width
         $error("pwm_timebase: CNT_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] prd_act;
   logic [CNT_W-1:0] cmp_act;
   logic [CNT_W-1:0] phs_q;
   logic             at_zero;
   logic             phase_take;

   assign at_zero    = (cnt_o == '0);
   assign phase_take = phase_en & sync_in;

   always_ff @(posedge clk) begin
      if (!rst_n)
         phs_q <= '0;
      else if (phs_wr)
         phs_q <= phs_wdata;
   end

   pwmtb_shadow #(.W(CNT_W)) u_prd (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (prd_wr),
      .wdata    (prd_wdata),
      .load     (at_zero),
      .active_q (prd_act)
   );

   pwmtb_shadow #(.W(CNT_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (cmp_wr),
      .wdata    (cmp_wdata),
      .load     (at_zero),
      .active_q (cmp_act)
   );

   pwmtb_counter #(.W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .period     (prd_act),
      .phase      (phs_q),
      .phase_take (phase_take),
      .cnt_q      (cnt_o)
   );

   pwmtb_events #(.W(CNT_W), .SYNC_OUT_REG(SYNC_OUT_REG)) u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (cnt_o),
      .cmp      (cmp_act),
      .sync_in  (sync_in),
      .sync_sel (sync_sel),
      .pwm_a    (pwm_a),
      .zero_irq (zero_irq),
      .sync_out (sync_out)
   );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             phase_en,
   input logic             sync_sel,
   input logic             sync_in,
   input logic [CNT_W-1:0] cnt_o,
   input logic [CNT_W-1:0] prd_act,
   input logic [CNT_W-1:0] cmp_act,
   input logic [CNT_W-1:0] phs_q,
   input logic             pwm_a,
   input logic             zero_irq,
   input logic             sync_out
);
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!(phase_en && sync_in) && cnt_o < prd_act) |=> cnt_o == $past(cnt_o) + 1'b1); // R1

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!(phase_en && sync_in) && cnt_o >= prd_act) |=> cnt_o == '0); // R1

   AST_PRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o != '0) |=> $stable(prd_act)); // R2

   AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_en && sync_in) |=> cnt_o == $past(phs_q)); // R3

   AST_SYNC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!phase_en && cnt_o < prd_act) |=> cnt_o != '0); // R4

   AST_SYNC_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_sel && cnt_o == '0) |=> sync_out); // R5

   AST_SYNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      sync_sel |=> sync_out == $past(sync_in)); // R5

   AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o != '0) |=> $stable(cmp_act)); // R6

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o == cmp_act) |=> !pwm_a); // R7

   AST_IRQ_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o == '0) |=> zero_irq); // R8

   AST_IRQ_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o != '0) |=> !zero_irq); // R8
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .phase_en (phase_en),
   .sync_sel (sync_sel),
   .sync_in  (sync_in),
   .cnt_o    (cnt_o),
   .prd_act  (prd_act),
   .cmp_act  (cmp_act),
   .phs_q    (phs_q),
   .pwm_a    (pwm_a),
   .zero_irq (zero_irq),
   .sync_out (sync_out)
);

// File: tb/pwm_timebase_tb.sv
`timescale 1ns/1ps
module pwm_timebase_tb;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         prd_wr, cmp_wr, phs_wr;
   logic [W-1:0] prd_wdata, cmp_wdata, phs_wdata;
   logic         phase_en, sync_sel, sync_in;
   logic [W-1:0] cnt_o;
   logic         pwm_a, zero_irq, sync_out;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   pwm_timebase #(.CNT_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .prd_wr(prd_wr), .prd_wdata(prd_wdata),
      .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
      .phs_wr(phs_wr), .phs_wdata(phs_wdata),
      .phase_en(phase_en), .sync_sel(sync_sel), .sync_in(sync_in),
      .cnt_o(cnt_o), .pwm_a(pwm_a), .zero_irq(zero_irq), .sync_out(sync_out)
   );

   // Reference model, built from the requirements
   logic [W-1:0] m_cnt, m_prd_sh, m_prd, m_cmp_sh, m_cmp, m_phs;
   logic         m_a, m_irq, m_sout;
   string        cnt_tag;

   function automatic logic [W-1:0] next_cnt(input logic [W-1:0] c, input logic [W-1:0] p,
                                              input logic [W-1:0] ph, input logic take);
      if (take)    return ph;
      if (c >= p)  return '0;
      return c + 1'b1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = '0; m_prd_sh = '0; m_prd = '0; m_cmp_sh = '0; m_cmp = '0; m_phs = '0;
         m_a = 1'b0; m_irq = 1'b0; m_sout = 1'b0; cnt_tag = "R9";
      end else begin
         logic         z, hit, take;
         logic [W-1:0] old_cnt;
         old_cnt = m_cnt;
         z       = (old_cnt == '0);
         hit     = (old_cnt == m_cmp);
         take    = phase_en && sync_in;
         cnt_tag = take ? "R3" : (sync_in ? "R4" : "R1");
         m_cnt   = next_cnt(old_cnt, m_prd, m_phs, take);
         if (hit)    m_a = 1'b0;
         else if (z) m_a = 1'b1;
         m_irq  = z;
         m_sout = sync_sel ? sync_in : z;
         if (z) begin
            m_prd = m_prd_sh;
            m_cmp = m_cmp_sh;
         end
         if (prd_wr) m_prd_sh = prd_wdata;
         if (cmp_wr) m_cmp_sh = cmp_wdata;
         if (phs_wr) m_phs    = phs_wdata;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cnt_o == m_cnt, cnt_tag, 32'(cnt_o), 32'(m_cnt));
         chk(pwm_a == m_a, "R7 pwm_a", 32'(pwm_a), 32'(m_a));
         chk(zero_irq == m_irq, "R8 zero_irq", 32'(zero_irq), 32'(m_irq));
         chk(sync_out == m_sout, "R5 sync_out", 32'(sync_out), 32'(m_sout));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic idle();
      prd_wr = 1'b0; cmp_wr = 1'b0; phs_wr = 1'b0; sync_in = 1'b0;
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         idle();
      end
   endtask

   task automatic wait_cnt(input logic [W-1:0] v, input int lim, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < lim && !seen; i++) begin
         @(negedge clk);
         idle();
         if (cnt_o == v) seen = 1'b1;
      end
   endtask

   initial begin
      bit          seen;
      logic [W-1:0] maxc;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; phase_en = 1'b0; sync_sel = 1'b0;
      prd_wdata = '0; cmp_wdata = '0; phs_wdata = '0;
      idle();
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(cnt_o == '0, "R9 cnt", 32'(cnt_o), 0);
      chk(pwm_a == 1'b0, "R9 pwm_a", 32'(pwm_a), 0);
      chk(zero_irq == 1'b0, "R9 irq", 32'(zero_irq), 0);
      chk(sync_out == 1'b0, "R9 sync_out", 32'(sync_out), 0);
      rst_n = 1'b1;

      // period 9, compare 4; counter sits at 0 so load is quick (R2, R6)
      prd_wr = 1'b1; prd_wdata = 16'd9; cmp_wr = 1'b1; cmp_wdata = 16'd4;
      step(25);

      // R6: compare write mid-period waits for the next zero
      wait_cnt(16'd2, 20, seen);
      cmp_wr = 1'b1; cmp_wdata = 16'd7;
      wait_cnt(16'd6, 20, seen);
      chk(seen && pwm_a == 1'b0, "R6 old compare still active", 32'(pwm_a), 0);
      wait_cnt(16'd0, 20, seen);
      wait_cnt(16'd6, 20, seen);
      chk(seen && pwm_a == 1'b1, "R6 new compare active", 32'(pwm_a), 1);

      // R2: period write mid-period waits for the next zero
      wait_cnt(16'd3, 20, seen);
      prd_wr = 1'b1; prd_wdata = 16'd5;
      wait_cnt(16'd9, 20, seen);
      chk(seen, "R2 old period kept", 32'(seen), 1);
      @(negedge clk); idle();
      maxc = '0;
      for (int i = 0; i < 18; i++) begin
         @(negedge clk);
         if (cnt_o > maxc) maxc = cnt_o;
      end
      chk(maxc == 16'd5, "R2 new period", 32'(maxc), 5);

      // R7: compare 0, clear wins over set, pwm_a stays low
      cmp_wr = 1'b1; cmp_wdata = 16'd0;
      step(14);
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         chk(pwm_a == 1'b0, "R7 clear priority", 32'(pwm_a), 0);
      end
      cmp_wr = 1'b1; cmp_wdata = 16'd3;
      step(10);

      // R4: sync ignored as master
      phase_en = 1'b0; phs_wr = 1'b1; phs_wdata = 16'd4;
      @(negedge clk); idle();
      wait_cnt(16'd1, 10, seen);
      sync_in = 1'b1;
      @(negedge clk); idle();
      chk(cnt_o == 16'd2, "R4 sync ignored", 32'(cnt_o), 2);

      // R3: sync reloads phase as slave (4 is a nonzero phase, R8 no irq)
      phase_en = 1'b1; sync_in = 1'b1;
      @(negedge clk); idle();
      chk(cnt_o == 16'd4, "R3 phase load", 32'(cnt_o), 4);
      @(negedge clk);
      chk(zero_irq == 1'b0, "R8 no irq from phase", 32'(zero_irq), 0);

      // R5 passthrough
      sync_sel = 1'b1; sync_in = 1'b1; phase_en = 1'b0;
      @(negedge clk); idle();
      chk(sync_out == 1'b1, "R5 pass high", 32'(sync_out), 1);
      @(negedge clk);
      chk(sync_out == 1'b0, "R5 pass low", 32'(sync_out), 0);

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         idle();
         if ($urandom_range(0, 19) == 0) begin prd_wr = 1'b1; prd_wdata = W'($urandom_range(0, 20)); end
         if ($urandom_range(0, 9)  == 0) begin cmp_wr = 1'b1; cmp_wdata = W'($urandom_range(0, 22)); end
         if ($urandom_range(0, 14) == 0) begin phs_wr = 1'b1; phs_wdata = W'($urandom_range(0, 24)); end
         if ($urandom_range(0, 9)  == 0) sync_in = 1'b1;
         if ($urandom_range(0, 49) == 0) phase_en = ~phase_en;
         if ($urandom_range(0, 99) == 0) sync_sel = ~sync_sel;
      end
      @(negedge clk); idle();
      @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule